// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block sequences an open-drain system reset line that both the chip and outside devices may pull low. It watches the line through a synchronizer. It accepts an internal reset request, a power-on indication and a clock-lock flag. It turns any reset event into a pull-down of guaranteed minimum length. Each pull-down is followed by a short window in which the line is released and left alone. At the end of that window the line is sampled. A high level completes the sequence and fires a one-cycle start pulse for reset exception handling. A low level causes another full pull-down, and this release and sample loop repeats until the line is seen high.

A second output resets the on-chip peripheral modules. It asserts only after the reset sequence has been active for a set number of cycles, and it drops when the sequence completes. All durations are counted in system clock cycles. The pull-down length, the release window and the module reset hold time are parameters, so shorter values can be used in simulation.

Top module: `rstpin_seq`

## Requirements
- R1: While `rst_n` is low, `pin_pull` is 1, and both `exc_start` and `mod_rst` are 0.
- R2: While `por` is high, or while `pll_lock` is low after power-on, `pin_pull` stays 1. Once `por` is low and `pll_lock` is high, the pull continues for exactly DRIVE_CYC more cycles. A `por` that rises at any time makes `pin_pull` 1 in the next cycle.
- R3: A rise of `int_req` while the block is idle starts a pull of exactly DRIVE_CYC cycles, even when the request lasts only a few cycles.
- R4: If `int_req` is still high when DRIVE_CYC cycles have passed, the pull continues until the first cycle in which `int_req` is seen low.
- R5: An outside low level on the pin that lasts at least SYNC_STAGES+1 cycles is captured. While the outside device holds the line low, the block does not pull (`pin_pull`=0) and `mod_rst` can assert. Once the line is seen high again, the block pulls for exactly DRIVE_CYC cycles.
- R6: Every pull that ends is followed by exactly RELEASE_CYC cycles with `pin_pull`=0, before either the start pulse or a new pull.
- R7: When the synchronized pin reads 1 at the end of the release window, `exc_start` is 1 for exactly one cycle, in the first cycle after the window. This happens once per completed sequence.
- R8: When the pin reads 0 at the end of the release window, another pull of exactly DRIVE_CYC cycles starts. The loop repeats until the pin reads 1.
- R9: An `int_req` during the release window restarts a full DRIVE_CYC pull in the next cycle.
- R10: `mod_rst` is 1 only after the sequence has been busy for MODRST_HOLD consecutive cycles; it becomes 1 in cycle MODRST_HOLD+1. It is 0 in the cycle in which `exc_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pin_in | input | 1 | Raw level of the reset line (1 = high) |
| int_req | input | 1 | Internal reset request, active high |
| por | input | 1 | Power-on indication, active high |
| pll_lock | input | 1 | Clock synthesizer lock flag |
| pin_pull | output | 1 | Enables the open-drain pull-down of the reset line |
| mod_rst | output | 1 | Reset to the on-chip peripheral modules, active high |
| exc_start | output | 1 | One-cycle pulse that marks the start of reset exception processing |

## Verification
The bound checker watches properties that hold in every cycle. Every pull that ends has lasted at least DRIVE_CYC cycles. A power-on or an active request keeps the pin pulled. The start pulse is one cycle wide and never coincides with a pull or with the module reset. The module reset never asserts before the hold count has been reached. The exact lengths of each pull and of each release window, the retry loop on a pin held low, the restart of the pull by a request during the release window, and the capture of an outside pull can only be shown by the bench's scenarios. The scenarios compare a queue of expected pulse, gap and start events with what the design produces.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

  typedef enum logic [2:0] {
    ST_POR     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_EXT     = 3'd2,
    ST_DRIVE   = 3'd3,
    ST_RELEASE = 3'd4
  } rst_state_e;

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rstpin_timer.sv
module rstpin_timer #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             done
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (en && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/rstpin_hold.sv
module rstpin_hold #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic mod_rst
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!busy)               cnt_d = '0;
    else if (cnt_q != HOLD_V) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mod_rst = busy && (cnt_q == HOLD_V);

endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
  import rstpin_pkg::*;
#(
  parameter int DRIVE_CYC   = 512,
  parameter int RELEASE_CYC = 10,
  parameter int MODRST_HOLD = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic int_req,
  input  logic por,
  input  logic pll_lock,
  output logic pin_pull,
  output logic mod_rst,
  output logic exc_start
);

  localparam int MAXC = (DRIVE_CYC > RELEASE_CYC) ? DRIVE_CYC : RELEASE_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] DRIVE_LD   = TW'(DRIVE_CYC - 1);
  localparam logic [TW-1:0] RELEASE_LD = TW'(RELEASE_CYC - 1);

  rst_state_e    state_q, state_d;
  logic          exc_q, exc_d;
  logic          pin_s;
  logic          t_load, t_en, t_done;
  logic [TW-1:0] t_val;
  logic          busy;

  rstpin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  rstpin_timer #(.WIDTH(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(t_en), .load(t_load),
    .load_val(t_val), .done(t_done)
  );

  rstpin_hold #(.HOLD(MODRST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mod_rst(mod_rst)
  );

  // next-state decision
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = DRIVE_LD;
    exc_d   = 1'b0;
    if (por) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_POR: if (pll_lock) begin
          state_d = ST_DRIVE; t_load = 1'b1;
        end
        ST_IDLE: if (int_req) begin
          state_d = ST_DRIVE; t_load = 1'b1;
        end else if (!pin_s) begin
          state_d = ST_EXT;
        end
        ST_EXT: if (pin_s) begin
          state_d = ST_DRIVE; t_load = 1'b1;
        end
        ST_DRIVE: if (t_done && !int_req) begin
          state_d = ST_RELEASE; t_load = 1'b1; t_val = RELEASE_LD;
        end
        ST_RELEASE: if (int_req) begin
          state_d = ST_DRIVE; t_load = 1'b1;
        end else if (t_done) begin
          if (pin_s) begin
            state_d = ST_IDLE; exc_d = 1'b1;
          end else begin
            state_d = ST_DRIVE; t_load = 1'b1;
          end
        end
        default: state_d = ST_POR;
      endcase
    end
  end

  assign t_en = (state_q == ST_DRIVE) || (state_q == ST_RELEASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      exc_q   <= exc_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign pin_pull  = (state_q == ST_POR) || (state_q == ST_DRIVE);
  assign exc_start = exc_q;

endmodule

// File: rtl/rstpin_seq_chk.sv
module rstpin_seq_chk #(
  parameter int DRIVE_CYC   = 512,
  parameter int MODRST_HOLD = 4
) (
  input logic clk,
  input logic rst_n,
  input logic por,
  input logic int_req,
  input logic pin_pull,
  input logic mod_rst,
  input logic exc_start,
  input logic busy
);

  localparam int RW = $clog2(DRIVE_CYC + 1);
  localparam int HW = $clog2(MODRST_HOLD + 1);

  logic [RW-1:0] pull_run;
  logic [HW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_run <= '0;
      busy_run <= '0;
    end else begin
      if (!pin_pull)                        pull_run <= '0;
      else if (pull_run != RW'(DRIVE_CYC))  pull_run <= pull_run + 1'b1;
      if (!busy)                            busy_run <= '0;
      else if (busy_run != HW'(MODRST_HOLD)) busy_run <= busy_run + 1'b1;
    end
  end

  AST_POR_FORCES_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> pin_pull);  // R2

  AST_REQ_KEEPS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && pin_pull && !por) |=> pin_pull);  // R4

  AST_PULL_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_pull && pull_run != '0) |-> (pull_run == RW'(DRIVE_CYC)));  // R3

  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);  // R7

  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |-> (!pin_pull && !mod_rst));  // R10

  AST_MODRST_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |-> (busy && busy_run == HW'(MODRST_HOLD)));  // R10

endmodule

bind rstpin_seq rstpin_seq_chk #(
  .DRIVE_CYC(DRIVE_CYC), .MODRST_HOLD(MODRST_HOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .por(por), .int_req(int_req),
  .pin_pull(pin_pull), .mod_rst(mod_rst), .exc_start(exc_start), .busy(busy)
);

// File: tb/rstpin_seq_bench.sv
module rstpin_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D = 20;
  localparam int R = 10;
  localparam int H = 4;

  typedef enum int { K_PULSE, K_GAP, K_EXC } kind_e;
  typedef struct {
    kind_e kind;
    int    val;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_req = 1'b0;
  logic por = 1'b1;
  logic pll_lock = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_pull, mod_rst, exc_start;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  item_t exp_q[$];

  int  hicnt = 0;
  int  lowcnt = 0;
  bit  in_seq = 1'b0;
  bit  prev_pull = 1'b1;
  bit  prev_exc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in = !(pin_pull || ext_low);

  rstpin_seq #(.DRIVE_CYC(D), .RELEASE_CYC(R), .MODRST_HOLD(H), .SYNC_STAGES(2)) u_rstpin_seq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .int_req(int_req), .por(por),
    .pll_lock(pll_lock), .pin_pull(pin_pull), .mod_rst(mod_rst), .exc_start(exc_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input kind_e k, input int v, input string req);
    item_t it;
    it.kind = k; it.val = v; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic compare(input kind_e k, input int v);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6", int'(k), -1);
    end else begin
      it = exp_q.pop_front();
      check(it.kind == k && (it.val < 0 || it.val == v), it.req,
            int'(k) * 1000 + v, int'(it.kind) * 1000 + it.val);
    end
  endtask

  // monitor: turns observed waveforms into events and compares them with the queue
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (pin_pull) begin
        if (!prev_pull) begin
          if (in_seq) compare(K_GAP, lowcnt);
          hicnt = 1;
        end else hicnt++;
      end else begin
        if (prev_pull) begin
          compare(K_PULSE, hicnt);
          lowcnt = 1;
          in_seq = 1'b1;
        end else lowcnt++;
      end
      if (prev_exc) check(!exc_start, "R7", int'(exc_start), 0);
      if (exc_start) begin
        compare(K_EXC, lowcnt);
        in_seq = 1'b0;
      end
      prev_pull = pin_pull;
      prev_exc  = exc_start;
    end
  end

  task automatic wait_pull(input bit v);
    do @(negedge clk); while (pin_pull != v);
  endtask

  task automatic wait_exc();
    do @(negedge clk); while (!exc_start);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", 0, 1);
    finish_run();
  end

  initial begin
    int cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pin_pull == 1'b1, "R1", int'(pin_pull), 1);
    check(exc_start == 1'b0, "R1", int'(exc_start), 0);
    check(mod_rst == 1'b0, "R1", int'(mod_rst), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2: power-on, lock, then DRIVE_CYC cycles
    push(K_PULSE, -1, "R2");
    push(K_EXC, R + 1, "R6");
    pll_lock = 1'b1;
    repeat (10) @(negedge clk);
    check(pin_pull == 1'b1, "R2", int'(pin_pull), 1);
    por = 1'b0; pll_lock = 1'b0;
    repeat (10) @(negedge clk);
    check(pin_pull == 1'b1, "R2", int'(pin_pull), 1);
    pll_lock = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (pin_pull) begin cnt++; @(negedge clk); end
    check(cnt == D, "R2", cnt, D);
    wait_exc();

    // R3 + R10: short internal request, module reset timing
    push(K_PULSE, D, "R3");
    push(K_EXC, R + 1, "R7");
    int_req = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 3) int_req = 1'b0;
      if (k == H) check(mod_rst == 1'b0, "R10", int'(mod_rst), 0);
      if (k == H + 1) check(mod_rst == 1'b1, "R10", int'(mod_rst), 1);
    end
    do @(negedge clk); while (!exc_start);
    check(mod_rst == 1'b0, "R10", int'(mod_rst), 0);
    repeat (3) @(negedge clk);

    // R4: long internal request extends the pull
    push(K_PULSE, D + 15, "R4");
    push(K_EXC, R + 1, "R6");
    int_req = 1'b1;
    repeat (D + 15) @(negedge clk);
    int_req = 1'b0;
    wait_exc();

    // R5: outside device pulls the line
    push(K_PULSE, D, "R5");
    push(K_EXC, R + 1, "R7");
    ext_low = 1'b1;
    repeat (30) @(negedge clk);
    check(pin_pull == 1'b0, "R5", int'(pin_pull), 0);
    check(mod_rst == 1'b1, "R5", int'(mod_rst), 1);
    ext_low = 1'b0;
    wait_exc();

    // R8: line still low after release -> retry
    push(K_PULSE, D, "R3");
    push(K_GAP, R, "R8");
    push(K_PULSE, D, "R8");
    push(K_EXC, R + 1, "R6");
    int_req = 1'b1;
    @(negedge clk);
    int_req = 1'b0;
    ext_low = 1'b1;
    wait_pull(1'b0);
    wait_pull(1'b1);
    repeat (3) @(negedge clk);
    ext_low = 1'b0;
    wait_exc();

    // R9: request during release restarts the pull
    push(K_PULSE, D, "R3");
    push(K_GAP, 3, "R9");
    push(K_PULSE, D, "R9");
    push(K_EXC, R + 1, "R7");
    int_req = 1'b1;
    @(negedge clk);
    int_req = 1'b0;
    wait_pull(1'b0);
    repeat (2) @(negedge clk);
    int_req = 1'b1;
    @(negedge clk);
    int_req = 1'b0;
    wait_exc();

    // R2: power-on from idle has priority
    push(K_PULSE, D + 5, "R2");
    push(K_EXC, R + 1, "R6");
    por = 1'b1;
    repeat (5) @(negedge clk);
    por = 1'b0;
    wait_exc();

    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    finish_run();
  end

endmodule